// File: doc/BRIEF.md
# Multiplexed Asynchronous Bus Target Interface

This block is the target side of an asynchronous 16-bit bus. The same lines carry the address and then the data of a transfer. The master places the address on the shared lines and asserts the sync strobe. The block latches the address and decides whether the cycle is meant for it. It then serves word reads, word writes and byte writes from a small internal register file. Each data phase completes through a fully interlocked reply handshake. If the block never replies, the master ends the cycle with a bus timeout.

The block occupies a naturally aligned window of word registers inside the top 4K-word I/O page. A separate, predecoded page-select input marks accesses to that page. All bus control lines are active low (0 = asserted).

The strobes are brought into the local clock domain through a short synchronizer chain. The address lines, page select, write-byte flag and write data are sampled directly. They are stable whenever the synchronized strobes say they are.

The shared lines are split into an input bus and an output bus with an enable. The output enable is high only while the block drives read data.

Top module: `mux_bus_target`

## Requirements
- R1: After reset, `replyN` is 1, `dalOe` is 0, `dalOut` is 0 and every internal register reads back as 0x0000.
- R2: When sync asserts, the block latches the address. It selects itself only if all of the following hold: `ioPageN` is 0, address bits 15:13 are all ones, and address bits 12:(IDX_W+1) equal the same bits of `BASE_OFFSET`. With the defaults, the block responds to byte addresses 0xE140 to 0xE14F, and register k sits at 0xE140 + 2k.
- R3: In a cycle that does not select the block, `replyN` stays 1, `dalOe` stays 0, and no register changes.
- R4: In a selected cycle, asserting `dinN` makes the block drive the addressed register word on `dalOut`, with `dalOe` at 1, and then assert `replyN`. The data stays valid and unchanged for as long as reply stays asserted.
- R5: A write with `doutN` asserted and `wtbtN` at 1 is a word write. It stores all 16 bits of `dalIn`, and address bit 0 is ignored.
- R6: A write with `wtbtN` at 0 is a byte write. If address bit 0 is 0, it stores `dalIn[7:0]` into the low byte. If address bit 0 is 1, it stores `dalIn[15:8]` into the high byte. The other byte keeps its value.
- R7: Once asserted, `replyN` stays at 0 until the strobe that caused it negates. It then returns to 1, and `dalOe` falls on the same clock edge.
- R8: Within one sync period, a read followed by a write to the latched address (read-modify-write) completes both handshakes. The write lands in the same register that was read.
- R9: With `ioPageN` at 1, the block ignores the cycle even when the address bits match its window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local clock |
| rstN | input | 1 | Asynchronous active-low reset |
| dalIn | input | 16 | Shared address/data lines as received |
| busSyncN | input | 1 | Sync strobe, active low; starts a cycle and marks the address |
| ioPageN | input | 1 | Predecoded I/O-page select, active low |
| dinN | input | 1 | Read strobe (data toward the master), active low |
| doutN | input | 1 | Write strobe (data toward the target), active low |
| wtbtN | input | 1 | Write-byte flag, active low; 0 during a write means a byte write |
| dalOut | output | 16 | Read data toward the shared lines |
| dalOe | output | 1 | Drive enable for `dalOut`; 0 whenever read data is not driven |
| replyN | output | 1 | Reply handshake, active low |

## Verification
The bench runs each access kind against the register file:
- Word writes to even and odd addresses show whether bit 0 is wrongly used for word accesses.
- Byte writes to each lane show whether lanes are swapped and whether the untouched byte is kept.
- Addresses just below, just above and at the ends of the window show off-by-one faults in the window decode. A high-bits mismatch, and a negated page select with matching low bits, show whether each term of the select condition is checked.
- Stretched strobes and a read-modify-write under a single sync show whether reply is released early and whether the second phase reuses the latched address.

// File: rtl/mbt_pkg.sv
package mbt_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DECODE,
    ST_ARMED,
    ST_READ_HOLD,
    ST_WRITE_HOLD,
    ST_IGNORE
  } ctrlState_t;

  // Strobes the control sends to the datapath, one clock each
  typedef struct packed {
    logic latchAddr;
    logic loadRead;
    logic commitWrite;
    logic releaseLines;
  } dpStrobe_t;

endpackage

// File: rtl/mbt_sync.sv
module mbt_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncN,
  output logic [WIDTH-1:0] syncedN
);

  logic [WIDTH-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain[0] <= '1;
        else       chain[0] <= asyncN;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain[s] <= '1;
        else       chain[s] <= chain[s-1];
      end
    end
  end

  assign syncedN = chain[STAGES-1];

endmodule

// File: rtl/mbt_ctrl.sv
module mbt_ctrl
  import mbt_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      syncA,
  input  logic      dinA,
  input  logic      doutA,
  input  logic      devSel,
  output dpStrobe_t strobe,
  output logic      replyN
);

  ctrlState_t state, stateNext;
  logic       replyNext;

  always_comb begin
    stateNext = state;
    replyNext = replyN;
    strobe    = '0;
    unique case (state)
      ST_IDLE: begin
        if (syncA) begin
          strobe.latchAddr = 1'b1;
          stateNext        = ST_DECODE;
        end
      end
      ST_DECODE: begin
        stateNext = devSel ? ST_ARMED : ST_IGNORE;
      end
      ST_ARMED: begin
        if (!syncA) begin
          stateNext = ST_IDLE;
        end else if (dinA) begin
          strobe.loadRead = 1'b1;
          replyNext       = 1'b0;
          stateNext       = ST_READ_HOLD;
        end else if (doutA) begin
          strobe.commitWrite = 1'b1;
          replyNext          = 1'b0;
          stateNext          = ST_WRITE_HOLD;
        end
      end
      ST_READ_HOLD: begin
        if (!dinA) begin
          strobe.releaseLines = 1'b1;
          replyNext           = 1'b1;
          stateNext           = ST_ARMED;
        end
      end
      ST_WRITE_HOLD: begin
        if (!doutA) begin
          replyNext = 1'b1;
          stateNext = ST_ARMED;
        end
      end
      ST_IGNORE: begin
        if (!syncA) stateNext = ST_IDLE;
      end
      default: begin
        stateNext = ST_IDLE;
        replyNext = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      replyN <= 1'b1;
    end else begin
      state  <= stateNext;
      replyN <= replyNext;
    end
  end

endmodule

// File: rtl/mbt_datapath.sv
module mbt_datapath
  import mbt_pkg::*;
#(
  parameter int          DATA_W      = 16,
  parameter int          PAGE_W      = 13,
  parameter int unsigned BASE_OFFSET = 'h140,
  parameter int          REG_COUNT   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [DATA_W-1:0] dalIn,
  input  logic              ioPageA,
  input  logic              byteWrite,
  output logic              devSel,
  output logic [DATA_W-1:0] dalOut,
  output logic              dalOe
);

  localparam int IDX_W = $clog2(REG_COUNT);
  localparam int HALF  = DATA_W / 2;
  localparam logic [PAGE_W-1:0] BASE_VEC = PAGE_W'(BASE_OFFSET);

  logic [IDX_W:0]      offReg;
  logic [IDX_W-1:0]    idx;
  logic                hiLane;
  logic                winMatch;
  logic [DATA_W-1:0]   rdData;
  logic [DATA_W-1:0]   regFile [REG_COUNT];

  assign winMatch = ioPageA
                  && (&dalIn[DATA_W-1:PAGE_W])
                  && (dalIn[PAGE_W-1:IDX_W+1] == BASE_VEC[PAGE_W-1:IDX_W+1]);

  assign idx    = offReg[IDX_W:1];
  assign hiLane = offReg[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      offReg <= '0;
      devSel <= 1'b0;
    end else if (strobe.latchAddr) begin
      offReg <= dalIn[IDX_W:0];
      devSel <= winMatch;
    end
  end

  for (genvar g = 0; g < REG_COUNT; g++) begin : g_reg
    logic hitG;
    assign hitG = strobe.commitWrite && (idx == IDX_W'(g));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        regFile[g] <= '0;
      end else if (hitG) begin
        if (!byteWrite) begin
          regFile[g] <= dalIn;
        end else if (hiLane) begin
          regFile[g][DATA_W-1:HALF] <= dalIn[DATA_W-1:HALF];
        end else begin
          regFile[g][HALF-1:0] <= dalIn[HALF-1:0];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData <= '0;
      dalOe  <= 1'b0;
    end else if (strobe.loadRead) begin
      rdData <= regFile[idx];
      dalOe  <= 1'b1;
    end else if (strobe.releaseLines) begin
      dalOe  <= 1'b0;
    end
  end

  assign dalOut = dalOe ? rdData : '0;

endmodule

// File: rtl/mux_bus_target.sv
module mux_bus_target
  import mbt_pkg::*;
#(
  parameter int          SYNC_STAGES = 2,
  parameter int unsigned BASE_OFFSET = 'h140,
  parameter int          REG_COUNT   = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [15:0] dalIn,
  input  logic        busSyncN,
  input  logic        ioPageN,
  input  logic        dinN,
  input  logic        doutN,
  input  logic        wtbtN,
  output logic [15:0] dalOut,
  output logic        dalOe,
  output logic        replyN
);

  localparam int DATA_W = 16;
  localparam int PAGE_W = 13;

  logic [2:0] strobeSyncN;
  logic       syncA, dinA, doutA;
  logic       devSel;
  dpStrobe_t  strobe;

  mbt_sync #(.STAGES(SYNC_STAGES), .WIDTH(3)) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncN  ({busSyncN, dinN, doutN}),
    .syncedN (strobeSyncN)
  );

  assign syncA = !strobeSyncN[2];
  assign dinA  = !strobeSyncN[1];
  assign doutA = !strobeSyncN[0];

  mbt_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .syncA  (syncA),
    .dinA   (dinA),
    .doutA  (doutA),
    .devSel (devSel),
    .strobe (strobe),
    .replyN (replyN)
  );

  mbt_datapath #(
    .DATA_W      (DATA_W),
    .PAGE_W      (PAGE_W),
    .BASE_OFFSET (BASE_OFFSET),
    .REG_COUNT   (REG_COUNT)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .dalIn     (dalIn),
    .ioPageA   (!ioPageN),
    .byteWrite (!wtbtN),
    .devSel    (devSel),
    .dalOut    (dalOut),
    .dalOe     (dalOe)
  );

endmodule

// File: rtl/mbt_checker.sv
module mbt_checker (
  input logic clk,
  input logic rstN,
  input logic busSyncN,
  input logic dinN,
  input logic doutN,
  input logic replyN,
  input logic dalOe,
  input logic devSel
);

  AST_RESET_QUIET: assert property (@(posedge clk) !rstN |=> (replyN && !dalOe)); // R1

  AST_NO_REPLY_UNSELECTED: assert property (@(posedge clk) disable iff (!rstN)
    !devSel |-> replyN); // R3

  AST_DRIVE_ONLY_ON_READ: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dalOe) |-> !dinN); // R4

  AST_DRIVE_WITH_REPLY: assert property (@(posedge clk) disable iff (!rstN)
    dalOe |-> !replyN); // R4

  AST_NO_DRIVE_ON_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    dalOe |-> doutN); // R5

  AST_RELEASE_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(replyN) |-> (dinN && doutN)); // R7

  AST_REPLY_IN_SYNC: assert property (@(posedge clk) disable iff (!rstN)
    !replyN |-> !busSyncN); // R8

endmodule

bind mux_bus_target mbt_checker u_checker (
  .clk      (clk),
  .rstN     (rstN),
  .busSyncN (busSyncN),
  .dinN     (dinN),
  .doutN    (doutN),
  .replyN   (replyN),
  .dalOe    (dalOe),
  .devSel   (devSel)
);

// File: tb/tb_mux_bus_target.sv
module tb_mux_bus_target;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] dalIn = '0;
  logic        busSyncN = 1'b1, ioPageN = 1'b1, dinN = 1'b1, doutN = 1'b1, wtbtN = 1'b1;
  logic [15:0] dalOut;
  logic        dalOe, replyN;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  mux_bus_target dut (
    .clk(clk), .rstN(rstN), .dalIn(dalIn), .busSyncN(busSyncN), .ioPageN(ioPageN),
    .dinN(dinN), .doutN(doutN), .wtbtN(wtbtN), .dalOut(dalOut), .dalOe(dalOe), .replyN(replyN)
  );

  task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic waitReply(input logic level, output bit seen);
    seen = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (replyN == level) begin
        seen = 1;
        break;
      end
    end
  endtask

  task automatic startCycle(input logic [15:0] addr, input bit io);
    @(negedge clk);
    dalIn = addr;
    ioPageN = !io;
    @(negedge clk);
    busSyncN = 1'b0;
    repeat (5) @(negedge clk);
    dalIn = '0;
  endtask

  task automatic endCycle();
    busSyncN = 1'b1;
    ioPageN = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic doRead(output logic [15:0] data, output bit replied, output bit oeSeen);
    bit gone;
    data = '0;
    oeSeen = 0;
    dinN = 1'b0;
    waitReply(1'b0, replied);
    if (replied) begin
      @(negedge clk);
      data = dalOut;
      oeSeen = dalOe;
    end
    dinN = 1'b1;
    waitReply(1'b1, gone);
  endtask

  task automatic doWrite(input logic [15:0] data, input bit byteFlag, output bit replied);
    bit gone;
    dalIn = data;
    wtbtN = !byteFlag;
    @(negedge clk);
    doutN = 1'b0;
    waitReply(1'b0, replied);
    doutN = 1'b1;
    waitReply(1'b1, gone);
    wtbtN = 1'b1;
    dalIn = '0;
  endtask

  task automatic readAt(input logic [15:0] addr, input bit io, output logic [15:0] data, output bit replied);
    bit oe;
    startCycle(addr, io);
    doRead(data, replied, oe);
    endCycle();
  endtask

  task automatic writeAt(input logic [15:0] addr, input bit io, input logic [15:0] data,
                         input bit byteFlag, output bit replied);
    startCycle(addr, io);
    doWrite(data, byteFlag, replied);
    endCycle();
  endtask

  task automatic testReset();
    logic [15:0] d; bit r;
    check(replyN === 1'b1, "R1 reply released after reset", {15'd0, replyN}, 16'd1);
    check(dalOe === 1'b0 && dalOut === 16'h0, "R1 lines released after reset", dalOut, 16'h0);
    readAt(16'hE14A, 1, d, r);
    check(r && d === 16'h0000, "R1 register reset value", d, 16'h0000);
  endtask

  task automatic testWord();
    logic [15:0] d; bit r, rr;
    writeAt(16'hE140, 1, 16'hA5C3, 0, r);
    readAt(16'hE140, 1, d, rr);
    check(r && rr && d === 16'hA5C3, "R5 R4 word write then read reg0", d, 16'hA5C3);
    writeAt(16'hE14E, 1, 16'h1234, 0, r);
    readAt(16'hE14E, 1, d, rr);
    check(r && rr && d === 16'h1234, "R2 last register of window", d, 16'h1234);
  endtask

  task automatic testOddWord();
    logic [15:0] d; bit r, rr;
    writeAt(16'hE143, 1, 16'hBEEF, 0, r);
    readAt(16'hE142, 1, d, rr);
    check(r && rr && d === 16'hBEEF, "R5 word write ignores addr bit0", d, 16'hBEEF);
    readAt(16'hE143, 1, d, rr);
    check(rr && d === 16'hBEEF, "R5 word read at odd address", d, 16'hBEEF);
  endtask

  task automatic testByteLanes();
    logic [15:0] d; bit r, rr;
    writeAt(16'hE144, 1, 16'h1111, 0, r);
    writeAt(16'hE144, 1, 16'h77AB, 1, r);
    readAt(16'hE144, 1, d, rr);
    check(r && rr && d === 16'h11AB, "R6 byte write low lane", d, 16'h11AB);
    writeAt(16'hE145, 1, 16'hCD99, 1, r);
    readAt(16'hE144, 1, d, rr);
    check(r && rr && d === 16'hCDAB, "R6 byte write high lane", d, 16'hCDAB);
  endtask

  task automatic testWindow();
    logic [15:0] d; bit r, rr;
    writeAt(16'hE150, 1, 16'hFFFF, 0, r);
    check(!r, "R3 no reply above window", {15'd0, r}, 16'd0);
    writeAt(16'hE13E, 1, 16'hFFFF, 0, r);
    check(!r, "R2 no reply below window", {15'd0, r}, 16'd0);
    writeAt(16'h6140, 1, 16'hFFFF, 0, r);
    check(!r, "R2 no reply when high bits not all ones", {15'd0, r}, 16'd0);
    readAt(16'hE150, 1, d, rr);
    check(!rr && dalOe === 1'b0, "R3 no drive on unselected read", {15'd0, rr}, 16'd0);
    readAt(16'hE140, 1, d, rr);
    check(rr && d === 16'hA5C3, "R3 reg0 untouched by unselected writes", d, 16'hA5C3);
  endtask

  task automatic testIoPage();
    logic [15:0] d; bit r, rr;
    writeAt(16'hE142, 0, 16'h0000, 0, r);
    check(!r, "R9 no reply without page select", {15'd0, r}, 16'd0);
    readAt(16'hE142, 1, d, rr);
    check(rr && d === 16'hBEEF, "R9 register kept without page select", d, 16'hBEEF);
  endtask

  task automatic testRmw();
    logic [15:0] d; bit r, w, oe, rr;
    startCycle(16'hE146, 1);
    doRead(d, r, oe);
    check(r && oe && d === 16'h0000, "R8 rmw read phase", d, 16'h0000);
    doWrite(d + 16'h7777, 0, w);
    check(w, "R8 rmw write phase replied", {15'd0, w}, 16'd1);
    endCycle();
    readAt(16'hE146, 1, d, rr);
    check(rr && d === 16'h7777, "R8 rmw result", d, 16'h7777);
  endtask

  task automatic testHandshake();
    bit r, gone, held;
    startCycle(16'hE140, 1);
    dinN = 1'b0;
    waitReply(1'b0, r);
    held = r;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (replyN !== 1'b0 || dalOe !== 1'b1 || dalOut !== 16'hA5C3) held = 0;
    end
    check(held, "R7 R4 reply and data held while din asserted", dalOut, 16'hA5C3);
    dinN = 1'b1;
    waitReply(1'b1, gone);
    check(gone && dalOe === 1'b0 && dalOut === 16'h0, "R7 release after din negates", dalOut, 16'h0);
    @(negedge clk);
    dalIn = 16'h5A5A;
    @(negedge clk);
    doutN = 1'b0;
    waitReply(1'b0, r);
    held = r;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (replyN !== 1'b0) held = 0;
    end
    check(held, "R7 reply held while dout asserted", {15'd0, replyN}, 16'd0);
    doutN = 1'b1;
    waitReply(1'b1, gone);
    check(gone, "R7 reply released after dout negates", {15'd0, replyN}, 16'd1);
    dalIn = '0;
    endCycle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    testReset();
    testWord();
    testOddWord();
    testByteLanes();
    testWindow();
    testIoPage();
    testRmw();
    testHandshake();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule